// File: doc/BRIEF.md
# 8-bit Timer with CTC and Fast PWM Waveform Generation

This block is an 8-bit up-counter with two compare channels (A and B) and a waveform generator. It advances only on cycles where the external prescaler's `tick` strobe is high. A register write port selects the counting mode and the output behaviour of each channel, and loads both compare values and the count. There are three counting modes. In free-running mode the counter wraps from 0xFF to 0x00. In clear-on-compare (CTC) mode the counter restarts after it equals compare A. In single-slope fast PWM mode the counter runs from 0x00 to a TOP value and restarts, where TOP is either 0xFF or compare A.

Write addresses: 0 = control, 1 = compare A, 2 = compare B, 3 = count, 4 = flag clear. The control byte holds the mode code in bits [2:0], the channel A output mode in bits [4:3] and the channel B output mode in bits [6:5]; bit 7 is ignored. The mode codes are 2 = CTC, 3 = fast PWM with TOP 0xFF and 7 = fast PWM with TOP = compare A; any other code runs free. The output mode codes are 0 = off, 1 = toggle, 2 = clear and 3 = set. In fast PWM mode, code 2 is non-inverting and code 3 is inverting. In the flag-clear byte, a 1 in bit 0 clears the A match flag, bit 1 clears the B match flag and bit 2 clears the overflow flag. A write and a tick in the same cycle act together, except that a count write wins over the tick.

The counter contains a two-state phase machine. In CP_RUN, matches are live. CP_SKIP is entered from either state on a count write and left for CP_RUN on the next tick that has no count write; no match is reported while in CP_SKIP. Each channel has a waveform machine with three states: WF_OFF, WF_LOW and WF_HIGH. With output mode 0 the machine goes to WF_OFF. Otherwise, match and restart events move it between WF_LOW and WF_HIGH, and WF_OFF counts as a low level.

Top module: `tmr8_wavegen`

## Requirements
- R1: After synchronous reset the count is 0, both waveform outputs are 0 and all three flags are 0.
- R2: The count changes only on a tick or a count write. In free-running mode (codes other than 2, 3, 7) it steps by one and wraps 0xFF to 0x00; on every tick taken at 0xFF the overflow flag is set at the same edge.
- R3: In CTC mode (code 2), a tick taken while the count equals compare A returns the count to 0x00 and sets the A match flag at that same edge.
- R4: In CTC mode a compare A write takes effect for the next tick; if written below the current count, no A match occurs until the count has run to 0xFF, wrapped to 0x00 and climbed to the new value.
- R5: In CTC mode with output mode 1 (toggle) the output inverts on each match, giving a period of 2·(1+compare A) ticks (2 ticks when compare A is 0).
- R6: Fast PWM runs 0x00..TOP then restarts at 0x00, with TOP = 0xFF for code 3 and TOP = compare A for code 7.
- R7: Fast PWM output mode 2 (non-inverting) sets the output at the restart edge and clears it at the match edge; output is high for count values 0..compare, i.e. compare+1 ticks per period; restart wins if both coincide.
- R8: Fast PWM output mode 3 (inverting) clears the output at the restart edge and sets it at the match edge, high for TOP−compare ticks per period.
- R9: In fast PWM modes a compare write is held in a buffer and copied to the active compare value only at a restart edge; outside fast PWM it applies at once.
- R10: Output mode 0 forces the output to 0 from the next cycle, whatever the count does.
- R11: Flags stay set until written with 1 at their flag-clear bit (bit 0 A, bit 1 B, bit 2 overflow); other bits leave them alone, and a set in the same cycle as a clear wins.
- R12: After a count write, the next tick reports no compare match on either channel (no flag, no output change), although the CTC/PWM restart still happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable strobe from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 compare A, 2 compare B, 3 count, 4 flag clear) |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current count |
| oca | output | 1 | Channel A waveform |
| ocb | output | 1 | Channel B waveform |
| flag_cmpa | output | 1 | Sticky channel A match flag |
| flag_cmpb | output | 1 | Sticky channel B match flag |
| flag_ovf | output | 1 | Sticky overflow flag |

## Verification
A wrong active compare value or a missed buffer transfer shows up on `count` at the next restart: the counter wraps at the wrong TOP within one PWM period. A phase machine stuck in CP_SKIP shows up as a missing match flag on the first matching tick, and one stuck in CP_RUN as a spurious flag right after a count write. A waveform machine in the wrong state is visible on `oca`/`ocb` one edge after the event that should have moved it, and a duty-cycle count over a whole period catches off-by-one errors at the match or restart edge.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    // write address map
    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_CMPA  = 3'd1;
    localparam logic [2:0] ADR_COUNT = 3'd3;
    localparam logic [2:0] ADR_FLAGS = 3'd4;

    // counting mode codes
    localparam logic [2:0] MODE_CTC      = 3'd2;
    localparam logic [2:0] MODE_PWM_FULL = 3'd3;
    localparam logic [2:0] MODE_PWM_VAR  = 3'd7;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_CLEAR  = 2'd2,
        OUT_SET    = 2'd3
    } out_mode_e;

    typedef enum logic {
        CP_RUN  = 1'b0,
        CP_SKIP = 1'b1
    } cnt_phase_e;

    typedef enum logic [1:0] {
        WF_OFF  = 2'd0,
        WF_LOW  = 2'd1,
        WF_HIGH = 2'd2
    } wave_state_e;

endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3,
    parameter int NCH    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NCH-1:0]    ev_match,
    input  logic              ev_ovf,
    output logic [2:0]        mode,
    output out_mode_e         com [NCH],
    output logic [NCH-1:0]    ocr_wr,
    output logic              cnt_wr,
    output logic [NCH-1:0]    flag_match,
    output logic              flag_ovf
);

    localparam int COM_LSB = 3;

    logic ctrl_wr;
    logic clr_wr;
    logic [NCH-1:0] clr_match;
    logic clr_ovf;
    logic unused_spare;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign clr_wr    = wr_en && (wr_addr == ADDR_W'(ADR_FLAGS));
    assign cnt_wr    = wr_en && (wr_addr == ADDR_W'(ADR_COUNT));
    assign clr_match = clr_wr ? wr_data[NCH-1:0] : '0;
    assign clr_ovf   = clr_wr && wr_data[NCH];
    assign unused_spare = wr_data[CNT_W-1];

    for (genvar g = 0; g < NCH; g++) begin : g_ocr_dec
        assign ocr_wr[g] = wr_en && (wr_addr == ADDR_W'(int'(ADR_CMPA) + g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            for (int i = 0; i < NCH; i++) com[i] <= OUT_OFF;
        end else if (ctrl_wr) begin
            mode <= wr_data[2:0];
            for (int i = 0; i < NCH; i++)
                com[i] <= out_mode_e'(wr_data[COM_LSB + 2*i +: 2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_match <= '0;
            flag_ovf   <= 1'b0;
        end else begin
            flag_match <= ev_match | (flag_match & ~clr_match);
            flag_ovf   <= ev_ovf | (flag_ovf & ~clr_ovf);
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_ovf && !clr_ovf) |=> flag_ovf); // R11
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_ovf |=> flag_ovf); // R2
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_match[0] |=> flag_match[0]); // R3

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] cnt,
    output logic             eff_tick,
    output logic             match_en,
    output logic             restart_ev,
    output logic             ovf_ev
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cnt_phase_e st_q, st_n;
    logic at_top;

    // phase register
    always_ff @(posedge clk) begin
        if (rst) st_q <= CP_RUN;
        else     st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            CP_RUN:  if (cnt_wr) st_n = CP_SKIP;
            CP_SKIP: if (cnt_wr) st_n = CP_SKIP;
                     else if (tick) st_n = CP_RUN;
            default: st_n = CP_RUN;
        endcase
    end

    assign eff_tick   = tick && !cnt_wr;
    assign match_en   = (st_q == CP_RUN);
    assign at_top     = (cnt == top_val);
    assign restart_ev = eff_tick && at_top;
    assign ovf_ev     = eff_tick && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt_wr)      cnt <= cnt_wdata;
        else if (restart_ev)  cnt <= '0;
        else if (eff_tick)    cnt <= cnt + 1'b1;
    end

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (eff_tick && !at_top) |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart_ev |=> (cnt == '0)); // R3
    AST_SKIP_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !match_en); // R12

endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eff_tick,
    input  logic             match_en,
    input  logic             restart_ev,
    input  logic             is_ctc,
    input  logic             is_pwm,
    input  out_mode_e        com,
    input  logic             ocr_wr,
    input  logic [CNT_W-1:0] ocr_wdata,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ocr_act,
    output logic             match_ev,
    output logic             oc
);

    logic [CNT_W-1:0] ocr_buf, ocr_buf_n;
    wave_state_e st_q, st_n;
    logic lvl, lvl_n;

    assign ocr_buf_n = ocr_wr ? ocr_wdata : ocr_buf;
    assign match_ev  = eff_tick && match_en && (cnt == ocr_act);

    always_ff @(posedge clk) begin
        if (rst) ocr_buf <= '0;
        else     ocr_buf <= ocr_buf_n;
    end

    // active compare: buffered in fast PWM, direct otherwise
    always_ff @(posedge clk) begin
        if (rst)             ocr_act <= '0;
        else if (!is_pwm)    ocr_act <= ocr_buf_n;
        else if (restart_ev) ocr_act <= ocr_buf;
    end

    // waveform state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= WF_OFF;
        else     st_q <= st_n;
    end

    assign lvl = (st_q == WF_HIGH);

    always_comb begin
        lvl_n = lvl;
        if (is_ctc) begin
            unique case (com)
                OUT_TOGGLE: if (match_ev) lvl_n = !lvl;
                OUT_CLEAR:  if (match_ev) lvl_n = 1'b0;
                OUT_SET:    if (match_ev) lvl_n = 1'b1;
                default:    lvl_n = lvl;
            endcase
        end else if (is_pwm) begin
            if (restart_ev) begin
                if (com == OUT_CLEAR)    lvl_n = 1'b1;
                else if (com == OUT_SET) lvl_n = 1'b0;
            end else if (match_ev) begin
                if (com == OUT_CLEAR)    lvl_n = 1'b0;
                else if (com == OUT_SET) lvl_n = 1'b1;
            end
        end
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            WF_OFF, WF_LOW, WF_HIGH: begin
                if (com == OUT_OFF) st_n = WF_OFF;
                else if (lvl_n)     st_n = WF_HIGH;
                else                st_n = WF_LOW;
            end
            default: st_n = WF_OFF;
        endcase
    end

    // output process
    always_comb begin
        oc = (st_q == WF_HIGH);
    end

    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
        (com == OUT_OFF) |=> !oc); // R10
    AST_PWM_BUFFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_pwm && !restart_ev) |=> $stable(ocr_act)); // R9
    AST_CTC_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (is_ctc && com == OUT_TOGGLE && match_ev) |=> (oc != $past(oc))); // R5

endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
    import tmr8_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              oca,
    output logic              ocb,
    output logic              flag_cmpa,
    output logic              flag_cmpb,
    output logic              flag_ovf
);

    localparam int NCH = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [2:0]       mode;
    out_mode_e        com [NCH];
    logic [NCH-1:0]   ocr_wr;
    logic             cnt_wr;
    logic [NCH-1:0]   flag_match;
    logic [NCH-1:0]   match_ev;
    logic [NCH-1:0]   oc;
    logic [CNT_W-1:0] ocr_act [NCH];
    logic [CNT_W-1:0] top_val;
    logic             is_ctc, is_pwm;
    logic             eff_tick, match_en, restart_ev, ovf_ev;

    assign is_ctc  = (mode == MODE_CTC);
    assign is_pwm  = (mode == MODE_PWM_FULL) || (mode == MODE_PWM_VAR);
    assign top_val = (is_ctc || mode == MODE_PWM_VAR) ? ocr_act[0] : CNT_MAX;

    tmr8_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NCH(NCH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ev_match   (match_ev),
        .ev_ovf     (ovf_ev),
        .mode       (mode),
        .com        (com),
        .ocr_wr     (ocr_wr),
        .cnt_wr     (cnt_wr),
        .flag_match (flag_match),
        .flag_ovf   (flag_ovf)
    );

    tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (wr_data),
        .top_val    (top_val),
        .cnt        (count),
        .eff_tick   (eff_tick),
        .match_en   (match_en),
        .restart_ev (restart_ev),
        .ovf_ev     (ovf_ev)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr8_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .eff_tick   (eff_tick),
            .match_en   (match_en),
            .restart_ev (restart_ev),
            .is_ctc     (is_ctc),
            .is_pwm     (is_pwm),
            .com        (com[g]),
            .ocr_wr     (ocr_wr[g]),
            .ocr_wdata  (wr_data),
            .cnt        (count),
            .ocr_act    (ocr_act[g]),
            .match_ev   (match_ev[g]),
            .oc         (oc[g])
        );
    end

    assign oca       = oc[0];
    assign ocb       = oc[1];
    assign flag_cmpa = flag_match[0];
    assign flag_cmpb = flag_match[1];

    AST_CTC_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (is_ctc && eff_tick && match_en && count == ocr_act[0]) |=> (flag_cmpa && count == '0)); // R3
    AST_NO_MATCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !(wr_en && wr_addr == ADDR_W'(ADR_FLAGS))) ##1 (!flag_cmpa && tick && !wr_en) |=> !flag_cmpa); // R12

endmodule

// File: tb/tb_tmr8_wavegen.sv
`timescale 1ns/1ps
module tb_tmr8_wavegen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count;
    logic oca, ocb, flag_cmpa, flag_cmpb, flag_ovf;

    always #5 clk = ~clk;

    tmr8_wavegen dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .oca(oca), .ocb(ocb),
        .flag_cmpa(flag_cmpa), .flag_cmpb(flag_cmpb), .flag_ovf(flag_ovf)
    );

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_cnt = 0, m_bufa = 0, m_bufb = 0, m_acta = 0, m_actb = 0;
    logic [2:0] m_mode = 0;
    logic [1:0] m_coma = 0, m_comb = 0;
    bit m_skip = 0, m_oa = 0, m_ob = 0, m_fa = 0, m_fb = 0, m_fo = 0;

    task automatic check(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit wave(logic [1:0] c, bit o, bit ctc, bit pwm, bit m, bit r);
        if (c == 0) return 1'b0;
        if (ctc) begin
            if (!m) return o;
            if (c == 1) return !o;
            return (c == 3);
        end
        if (pwm) begin
            if (r) return (c == 2) ? 1'b1 : (c == 3) ? 1'b0 : o;
            if (m) return (c == 2) ? 1'b0 : (c == 3) ? 1'b1 : o;
        end
        return o;
    endfunction

    task automatic m_step(bit t, bit we, logic [2:0] ad, logic [7:0] d);
        bit ctc, pwm, cw, et, rs, ma, mb, ov;
        logic [7:0] top, clr, na, nb;
        ctc = (m_mode == 2);
        pwm = (m_mode == 3) || (m_mode == 7);
        top = (m_mode == 2 || m_mode == 7) ? m_acta : 8'hFF;
        cw  = we && ad == 3;
        et  = t && !cw;
        rs  = et && m_cnt == top;
        ma  = et && !m_skip && m_cnt == m_acta;
        mb  = et && !m_skip && m_cnt == m_actb;
        ov  = et && m_cnt == 8'hFF;
        clr = (we && ad == 4) ? d : 8'h00;
        na  = (we && ad == 1) ? d : m_bufa;
        nb  = (we && ad == 2) ? d : m_bufb;
        m_oa = wave(m_coma, m_oa, ctc, pwm, ma, rs);
        m_ob = wave(m_comb, m_ob, ctc, pwm, mb, rs);
        m_fa = ma | (m_fa & !clr[0]);
        m_fb = mb | (m_fb & !clr[1]);
        m_fo = ov | (m_fo & !clr[2]);
        if (pwm) begin
            if (rs) begin m_acta = m_bufa; m_actb = m_bufb; end
        end else begin
            m_acta = na; m_actb = nb;
        end
        m_bufa = na; m_bufb = nb;
        m_cnt  = cw ? d : et ? (rs ? 8'h00 : m_cnt + 8'h01) : m_cnt;
        m_skip = cw ? 1'b1 : et ? 1'b0 : m_skip;
        if (we && ad == 0) begin
            m_mode = d[2:0]; m_coma = d[4:3]; m_comb = d[6:5];
        end
    endtask

    task automatic step(bit t, bit we, logic [2:0] ad, logic [7:0] d);
        tick = t; wr_en = we; wr_addr = ad; wr_data = d;
        m_step(t, we, ad, d);
        @(posedge clk); #1;
        total++;
        if (count !== m_cnt || oca !== m_oa || ocb !== m_ob ||
            flag_cmpa !== m_fa || flag_cmpb !== m_fb || flag_ovf !== m_fo) begin
            bad++;
            $display("FAIL %s model cnt/oa/ob/fa/fb/fo actual=%0d/%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d/%0d",
                     cur_req, count, oca, ocb, flag_cmpa, flag_cmpb, flag_ovf,
                     m_cnt, m_oa, m_ob, m_fa, m_fb, m_fo);
        end
        tick = 0; wr_en = 0;
    endtask

    task automatic wr(logic [2:0] ad, logic [7:0] d);
        step(1'b0, 1'b1, ad, d);
    endtask

    task automatic tk(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 8'd0);
    endtask

    task automatic half_a(output int n);
        bit prev;
        prev = oca; n = 0;
        for (int i = 0; i < 600; i++) begin
            tk(1); n++;
            if (oca != prev) break;
        end
    endtask

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, hi, mx;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1", count, 0, "count");
        check("R1", oca | ocb, 0, "outputs");
        check("R1", flag_cmpa + flag_cmpb + flag_ovf, 0, "flags");

        cur_req = "R2";
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 3'd0, 8'd0);
        check("R2", count, 0, "no-tick count");
        tk(255);
        check("R2", count, 255, "count at max");
        check("R2", flag_ovf, 0, "ovf before wrap");
        tk(1);
        check("R2", count, 0, "wrapped count");
        check("R2", flag_ovf, 1, "ovf at wrap");

        cur_req = "R11";
        wr(3'd4, 8'h07);
        check("R11", flag_ovf, 0, "ovf cleared");

        cur_req = "R3";
        wr(3'd1, 8'd5);
        wr(3'd0, 8'h0A);
        wr(3'd3, 8'd0);
        tk(5);
        check("R3", flag_cmpa, 0, "flag before match");
        tk(1);
        check("R3", count, 0, "ctc restart");
        check("R3", flag_cmpa, 1, "flag at match");
        check("R5", oca, 1, "first toggle");

        cur_req = "R5";
        half_a(n);
        check("R5", 2 * n, 2 * (1 + 5), "toggle period");
        wr(3'd1, 8'd0);
        half_a(n);
        check("R5", 2 * n, 2, "toggle period at compare 0");

        cur_req = "R4";
        wr(3'd1, 8'd20);
        wr(3'd3, 8'd10);
        wr(3'd4, 8'h07);
        tk(1);
        wr(3'd1, 8'd3);
        tk(244);
        check("R4", count, 255, "ran to max");
        check("R4", flag_cmpa, 0, "match missed");
        tk(1);
        check("R4", count, 0, "wrapped");
        check("R4", flag_ovf, 1, "ovf on wrap");
        tk(4);
        check("R4", count, 0, "restart at new compare");
        check("R4", flag_cmpa, 1, "late match");

        cur_req = "R12";
        wr(3'd4, 8'h07);
        wr(3'd3, 8'd3);
        tk(1);
        check("R12", count, 0, "restart still taken");
        check("R12", flag_cmpa, 0, "match blocked");
        tk(4);
        check("R12", flag_cmpa, 1, "next match seen");

        cur_req = "R7";
        wr(3'd2, 8'd64);
        wr(3'd0, 8'h43);
        tk(256);
        hi = 0; mx = 0;
        for (int i = 0; i < 256; i++) begin
            tk(1); hi += ocb; if (count > mx) mx = count;
        end
        check("R7", hi, 65, "non-inverting high ticks");
        check("R6", mx, 255, "top 0xFF");

        cur_req = "R8";
        wr(3'd0, 8'h63);
        tk(256);
        hi = 0;
        for (int i = 0; i < 256; i++) begin tk(1); hi += ocb; end
        check("R8", hi, 191, "inverting high ticks");

        cur_req = "R10";
        wr(3'd0, 8'h03);
        hi = 0;
        for (int i = 0; i < 300; i++) begin tk(1); hi += oca | ocb; end
        check("R10", hi, 0, "outputs off");

        cur_req = "R11";
        check("R11", flag_ovf, 1, "ovf sticky");
        wr(3'd4, 8'h04);
        check("R11", flag_ovf, 0, "ovf cleared by bit 2");
        check("R11", flag_cmpb, 1, "B flag untouched");

        cur_req = "R6";
        wr(3'd1, 8'd9);
        wr(3'd2, 8'd4);
        wr(3'd0, 8'h47);
        tk(300);
        hi = 0; mx = 0;
        for (int i = 0; i < 50; i++) begin
            tk(1); hi += ocb; if (count > mx) mx = count;
        end
        check("R6", mx, 9, "top from compare A");
        check("R7", hi, 25, "duty at variable top");

        cur_req = "R9";
        for (int i = 0; i < 20 && count != 2; i++) tk(1);
        wr(3'd1, 8'd30);
        tk(7);
        check("R9", count, 9, "old top still active");
        tk(1);
        check("R9", count, 0, "restart at old top");
        tk(10);
        check("R9", count, 10, "new top after restart");

        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            bit t, we;
            logic [2:0] ad;
            logic [7:0] d;
            logic [2:0] md;
            t  = ($urandom % 4) != 0;
            we = ($urandom % 8) == 0;
            ad = 3'($urandom % 5);
            d  = 8'($urandom);
            if (ad == 0) begin
                case ($urandom % 4)
                    0: md = 3'd2;
                    1: md = 3'd3;
                    2: md = 3'd7;
                    default: md = 3'd0;
                endcase
                d = {d[7:3], md};
            end
            if (ad == 3 && ($urandom % 4) != 0) we = 1'b0;
            step(t, we, ad, d);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule